// File: doc/BRIEF.md
# Byte-Lane Static Memory Core

A clocked, synthesizable word memory whose control decode mirrors an asynchronous static RAM: active-low select, write strobe, output strobe and two active-low byte-lane enables. Each lane is eight bits wide. The low lane covers word bits 7:0 and the high lane covers bits 15:8. The core stores and returns each lane independently. It drives one output-enable bit per lane so that the surrounding pad logic can tri-state each half of a shared data bus on its own. It also raises a combinational standby flag whenever the part is deselected.

The depth is 2^`ADDR_W` words. `ADDR_W` = 16 gives the full 65,536-word array. The default of 10 keeps elaboration small. Writes are taken on the rising clock edge. Read data and the lane output-enables come out either combinationally from the address and controls (`RD_REG` = 0) or one clock later through a registered path (`RD_REG` = 1).

The decode places every cycle in one of four modes:
- SLEEP: deselected, or both lanes disabled.
- WRITE: selected with the write strobe low.
- READ: selected, write strobe high, output strobe low.
- HOLD: selected with the outputs disabled.

The inputs alone pick the mode in every cycle, so any mode can follow any other. In the registered variant a state register holds last cycle's mode, and it resets to SLEEP.

Top module: `bl_sram_core`

## Requirements
- R1: When `ce_n`=0, `we_n`=0 and both lane enables are 0, the whole 16-bit `wr_data` word is stored at `addr` on the rising clock edge.
- R2: A write with only `lb_n`=0 stores bits 7:0 and only `ub_n`=0 stores bits 15:8. The stored byte of the disabled lane is left unchanged.
- R3: In READ mode, `lane_oe[0]` (the low lane, bits 7:0) is 1 exactly when `lb_n`=0 and `lane_oe[1]` (the high lane, bits 15:8) is 1 exactly when `ub_n`=0. A driven lane shows the stored byte on `rd_data`. An undriven lane shows zero.
- R4: `lane_oe` is 00 when `ce_n`=1, when `oe_n`=1, when both lane enables are 1, or during any write. During a write `oe_n` has no effect and the write still takes place.
- R5: `standby` is 1 in the same cycle when `ce_n`=1, or when `ce_n`=0 and both lane enables are 1. Otherwise it is 0.
- R6: With `ce_n`=0, `we_n`=1, `oe_n`=1 and at least one lane enable at 0 (HOLD), `standby` is 0, `lane_oe` is 00 and the memory is not changed.
- R7: No write happens when `ce_n`=1, or when `we_n`=0 with both lane enables at 1.
- R8: With `RD_REG`=0, `rd_data` and `lane_oe` follow the current inputs in the same cycle. With `RD_REG`=1 they show the values the same inputs would give one clock earlier, and `standby` stays combinational.
- R9: While `rst_n`=0 with the part deselected, `lane_oe` is 00, `rd_data` is 0 and `standby` is 1. In the registered variant `lane_oe` is held at 00 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and the registered read path act on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the registered read path |
| ce_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output strobe |
| lb_n | input | 1 | Active-low enable of the low lane, bits 7:0 |
| ub_n | input | 1 | Active-low enable of the high lane, bits 15:8 |
| addr | input | ADDR_W | Word address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data; an undriven lane reads zero |
| lane_oe | output | 2 | Per-lane bus drive enable, bit 0 low lane, bit 1 high lane |
| standby | output | 1 | Power-down indication |

## Verification
The assertions check the mode decode on every cycle:
- A deselected part or a part with both lanes disabled is always in standby, and a selected part with a lane enabled never is.
- No lane is driven during a write or while the output strobe is high.
- A lane whose enable is high is never driven.
- A completed write is visible at the same address in the following cycle.

Only the bench's scenarios can show that a single-lane write leaves the other stored byte intact, and that suppressed writes (deselected, both lanes off, HOLD) leave the memory unchanged when the data is read back later. The same holds for the one-cycle shift of the registered variant and for the extreme addresses.

// File: rtl/bl_mem_pkg.sv
package bl_mem_pkg;
    parameter int LANE_W = 8;
    parameter int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        MODE_SLEEP,
        MODE_HOLD,
        MODE_READ,
        MODE_WRITE
    } bl_mode_e;
endpackage

// File: rtl/bl_mode_decode.sv
module bl_mode_decode
    import bl_mem_pkg::*;
(
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [LANES-1:0] lane_en_n,
    output bl_mode_e         mode,
    output logic [LANES-1:0] lane_we,
    output logic [LANES-1:0] lane_drv,
    output logic             standby
);
    logic all_lanes_off;

    assign all_lanes_off = &lane_en_n;

    // mode selection
    always_comb begin
        if (ce_n || all_lanes_off) begin
            mode = MODE_SLEEP;
        end else if (!we_n) begin
            mode = MODE_WRITE;
        end else if (!oe_n) begin
            mode = MODE_READ;
        end else begin
            mode = MODE_HOLD;
        end
    end

    // per-mode outputs
    always_comb begin
        lane_we  = '0;
        lane_drv = '0;
        standby  = 1'b0;
        unique case (mode)
            MODE_SLEEP: standby  = 1'b1;
            MODE_HOLD:  standby  = 1'b0;
            MODE_READ:  lane_drv = ~lane_en_n;
            MODE_WRITE: lane_we  = ~lane_en_n;
            default:    standby  = 1'b1;
        endcase
    end
endmodule

// File: rtl/bl_lane_bank.sv
module bl_lane_bank
    import bl_mem_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter bit RD_REG = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    generate
        if (RD_REG) begin : g_reg_rd
            logic [LANE_W-1:0] rd_q;
            always_ff @(posedge clk) begin
                rd_q <= mem[addr];
            end
            assign rdata = rd_q;
        end else begin : g_comb_rd
            assign rdata = mem[addr];

            // R1 / R2: a write is visible at the same address one cycle later
            assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
                we ##1 (addr == $past(addr)) |-> rdata == $past(wdata));
        end
    endgenerate
endmodule

// File: rtl/bl_sram_core.sv
module bl_sram_core
    import bl_mem_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter bit RD_REG = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data,
    output logic [1:0]        lane_oe,
    output logic              standby
);
    logic [LANES-1:0]  lane_en_n;
    logic [LANES-1:0]  lane_we;
    logic [LANES-1:0]  lane_drv_d;
    logic [LANE_W-1:0] lane_rd [LANES];
    bl_mode_e          mode_d;

    assign lane_en_n = {ub_n, lb_n};

    bl_mode_decode u_decode (
        .ce_n      (ce_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .lane_en_n (lane_en_n),
        .mode      (mode_d),
        .lane_we   (lane_we),
        .lane_drv  (lane_drv_d),
        .standby   (standby)
    );

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            bl_lane_bank #(
                .ADDR_W (ADDR_W),
                .RD_REG (RD_REG)
            ) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (lane_we[l]),
                .addr  (addr),
                .wdata (wr_data[l*LANE_W +: LANE_W]),
                .rdata (lane_rd[l])
            );
            assign rd_data[l*LANE_W +: LANE_W] = lane_oe[l] ? lane_rd[l] : '0;
        end

        if (RD_REG) begin : g_reg_path
            bl_mode_e         mode_q;
            logic [LANES-1:0] drv_q;

            // state register
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mode_q <= MODE_SLEEP;
                    drv_q  <= '0;
                end else begin
                    mode_q <= mode_d;
                    drv_q  <= lane_drv_d;
                end
            end

            // outputs from the registered mode
            always_comb begin
                lane_oe = '0;
                unique case (mode_q)
                    MODE_READ:  lane_oe = drv_q;
                    MODE_SLEEP,
                    MODE_HOLD,
                    MODE_WRITE: lane_oe = '0;
                    default:    lane_oe = '0;
                endcase
            end

            // R8: drive enables appear one cycle after the read controls
            assert_reg_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (!ce_n && we_n && !oe_n) |=> lane_oe == ~$past({ub_n, lb_n}));
            // R9: reset holds the drive enables off
            assert_reset_quiet_R9: assert property (@(posedge clk)
                !rst_n |=> lane_oe == 2'b00);
        end else begin : g_comb_path
            assign lane_oe = lane_drv_d;

            assert_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (!ce_n && !we_n) |-> lane_oe == 2'b00);
            assert_oe_high_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
                oe_n |-> lane_oe == 2'b00);
            assert_lane_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (lb_n |-> !lane_oe[0]) and (ub_n |-> !lane_oe[1]));
        end
    endgenerate

    assert_ce_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> standby);
    assert_lanes_off_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_n && ub_n) |-> standby);
    assert_selected_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !(lb_n && ub_n)) |-> !standby);
    assert_sleep_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(standby) && !RD_REG |-> $past(lane_oe) == 2'b00);
endmodule

// File: tb/sim_bl_sram_core.sv
module sim_bl_sram_core;
    localparam int AW = 10;

    typedef struct {
        logic        sb;
        logic [1:0]  oe0;
        logic [15:0] d0;
        logic [1:0]  oe1;
        logic [15:0] d1;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wr_data = '0;
    logic [15:0]   rd0, rd1;
    logic [1:0]    oe0, oe1;
    logic          sb0, sb1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    exp_t        q[$];
    logic [15:0] shadow [1 << AW];
    logic [1:0]  prev_oe = 2'b00;
    logic [15:0] prev_d  = 16'h0000;

    always #2 clk = ~clk;

    bl_sram_core #(.ADDR_W(AW), .RD_REG(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .wr_data(wr_data),
        .rd_data(rd0), .lane_oe(oe0), .standby(sb0));

    bl_sram_core #(.ADDR_W(AW), .RD_REG(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .wr_data(wr_data),
        .rd_data(rd1), .lane_oe(oe1), .standby(sb1));

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // driver: applies one cycle of controls and pushes the expected outputs
    task automatic step(input logic c, w, o, lb, ub, input logic [AW-1:0] a,
                        input logic [15:0] wd, input string tag);
        exp_t        e;
        logic        sel;
        logic [1:0]  drv;
        logic [15:0] dat;
        @(negedge clk);
        ce_n = c; we_n = w; oe_n = o; lb_n = lb; ub_n = ub; addr = a; wr_data = wd;
        sel = !c && !(lb && ub);
        drv = (sel && w && !o) ? ~{ub, lb} : 2'b00;
        dat = 16'h0000;
        if (drv[0]) dat[7:0]  = shadow[a][7:0];
        if (drv[1]) dat[15:8] = shadow[a][15:8];
        e.sb  = !sel;
        e.oe0 = drv;
        e.d0  = dat;
        e.oe1 = rst_n ? prev_oe : 2'b00;
        e.d1  = rst_n ? prev_d : 16'h0000;
        e.tag = tag;
        q.push_back(e);
        prev_oe = drv;
        prev_d  = dat;
        if (sel && !w && rst_n) begin
            if (!lb) shadow[a][7:0]  = wd[7:0];
            if (!ub) shadow[a][15:8] = wd[15:8];
        end
    endtask

    // monitor: compares the outputs one time unit after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "standby", {15'd0, sb0}, {15'd0, e.sb});
                chk(e.tag, "lane_oe", {14'd0, oe0}, {14'd0, e.oe0});
                chk(e.tag, "rd_data", rd0, e.d0);
                chk("R8", "reg lane_oe", {14'd0, oe1}, {14'd0, e.oe1});
                chk("R8", "reg rd_data", rd1, e.d1);
                chk("R8", "reg standby", {15'd0, sb1}, {15'd0, e.sb});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog run did not complete actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state with the part deselected
        step(1, 1, 1, 1, 1, 10'd0, 16'h0000, "R9");
        step(1, 1, 0, 0, 0, 10'd0, 16'h0000, "R9");
        @(negedge clk);
        rst_n = 1'b1;
        // R1: full-word writes; R4: oe_n ignored during a write
        step(0, 0, 1, 0, 0, 10'd5,  16'hA55A, "R1");
        step(0, 0, 0, 0, 0, 10'd6,  16'h1234, "R4");
        step(0, 1, 0, 0, 0, 10'd5,  16'h0000, "R1");
        step(0, 1, 0, 0, 0, 10'd6,  16'h0000, "R4");
        // R2: single-lane writes keep the other byte
        step(0, 0, 1, 0, 1, 10'd5,  16'hFF77, "R2");
        step(0, 0, 1, 1, 0, 10'd6,  16'h9900, "R2");
        step(0, 1, 0, 0, 0, 10'd5,  16'h0000, "R2");
        step(0, 1, 0, 0, 0, 10'd6,  16'h0000, "R2");
        // R3: single-lane reads
        step(0, 1, 0, 0, 1, 10'd5,  16'h0000, "R3");
        step(0, 1, 0, 1, 0, 10'd5,  16'h0000, "R3");
        step(0, 1, 0, 1, 0, 10'd6,  16'h0000, "R3");
        // R5: standby on deselect and on both lanes off
        step(1, 1, 0, 0, 0, 10'd5,  16'h0000, "R5");
        step(0, 1, 0, 1, 1, 10'd5,  16'h0000, "R5");
        // R7: suppressed writes
        step(0, 0, 1, 1, 1, 10'd5,  16'h0000, "R7");
        step(1, 0, 1, 0, 0, 10'd6,  16'hDEAD, "R7");
        step(0, 1, 0, 0, 0, 10'd5,  16'h0000, "R7");
        step(0, 1, 0, 0, 0, 10'd6,  16'h0000, "R7");
        // R6: selected with outputs disabled
        step(0, 1, 1, 0, 1, 10'd5,  16'hBEEF, "R6");
        step(0, 1, 1, 0, 0, 10'd6,  16'hBEEF, "R6");
        step(0, 1, 0, 0, 0, 10'd5,  16'h0000, "R6");
        // R1 / R8: a spread of addresses including both ends
        for (int i = 0; i < 8; i++) begin
            logic [AW-1:0] a;
            a = (i == 0) ? '0 : (i == 7) ? '1 : AW'(i * 37 + 100);
            step(0, 0, 1, 0, 0, a, (16'h1111 * 16'(i)) ^ 16'h0F0F, "R1");
        end
        for (int i = 0; i < 8; i++) begin
            logic [AW-1:0] a;
            a = (i == 0) ? '0 : (i == 7) ? '1 : AW'(i * 37 + 100);
            step(0, 1, 0, 0, 0, a, 16'h0000, "R8");
        end
        step(1, 1, 1, 1, 1, 10'd0, 16'h0000, "R5");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule